// File: doc/BRIEF.md
# Masked Interrupt Request Selector

This block collects eight interrupt request lines and picks a single winner each clock cycle. A programmable mask register holds one enable bit for each line. Only lines that are both asserted and enabled take part in the selection. Among those, the line with the highest number always wins. The index of the winner is combined with a programmable base value to form an interrupt vector, which a CPU can use directly to look up its handler.

Configuration goes through a small write port with an enable, a one-bit address and a data word. Address 0 selects the mask register and address 1 selects the vector base register. The interrupt output, the winner index and the vector are all registered. They show the request and mask state sampled at the previous clock edge.

Top module: `irq_select`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the mask and the base are zero and `irq_out`, `irq_idx` and `irq_vec` are zero.
- R2: A mask bit of 1 enables the request line at the same bit position. An asserted line whose mask bit is 0 never affects `irq_out`, `irq_idx` or `irq_vec`.
- R3: After a clock edge, `irq_out` is 1 exactly when the request and mask values sampled at that edge have at least one bit position in common.
- R4: When `irq_out` is 1, `irq_idx` is the highest bit position that is set in both the sampled requests and the mask. The highest-numbered line has the highest priority.
- R5: When `irq_out` is 1, `irq_vec` is formed as follows:
  - bits 2:0 equal `irq_idx`;
  - bits 7:3 equal bits 7:3 of the last word written to the base register.
  
  Bits 2:0 of a base write are discarded.
- R6: When `irq_out` is 0, both `irq_idx` and `irq_vec` are 0.
- R7: A write with `cfg_we`=1 loads the mask (`cfg_addr`=0, from `cfg_wdata[7:0]`) or the base (`cfg_addr`=1) at the clock edge. The outputs registered at that same edge still use the previous register value. The new value first shows at the following edge.
- R8: The outputs change only at clock edges. They are registered from the requests sampled at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 1 | Register select: 0 mask, 1 vector base |
| cfg_wdata | input | 8 | Configuration write data |
| irq_req | input | 8 | Interrupt request lines, active high |
| irq_out | output | 1 | Interrupt to CPU: an enabled request is pending |
| irq_idx | output | 3 | Index of the winning line |
| irq_vec | output | 8 | Interrupt vector: base bits above, index below |

## Verification
Two things can happen at the same clock edge: a configuration write, and the selection of a winner from the live requests. The bench provokes this by holding all requests high while it writes a new mask or base in that cycle. The outputs of that edge must still reflect the old register value, and the outputs of the next edge must reflect the new one. Apart from this, the bench sweeps every mask value against every request pattern, with a base that changes for each mask. It computes the expected winner, flag and vector arithmetically.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;
   typedef enum logic {
      CFG_MASK = 1'b0,
      CFG_BASE = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 8,
   parameter int BASE_W    = 5,
   localparam int BASE_LO  = DATA_W - BASE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic                 addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [BASE_W-1:0]    base_q
);
   import irq_select_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         base_q <= '0;
      end else if (we) begin
         if (cfg_sel_e'(addr) == CFG_MASK)
            mask_q <= wdata[NUM_LINES-1:0];
         else
            base_q <= wdata[DATA_W-1:BASE_LO];
      end
   end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int NUM_LINES = 8
) (
   input  logic [NUM_LINES-1:0] req,
   input  logic [NUM_LINES-1:0] mask,
   output logic [NUM_LINES-1:0] live
);
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign live[g] = req[g] & mask[g];
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_LINES = 8,
   parameter bit HIGH_WINS = 1'b1,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] vec,
   output logic                 any,
   output logic [IDX_W-1:0]     idx
);
   assign any = |vec;

   if (HIGH_WINS) begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_LINES; i++)
            if (vec[i]) idx = IDX_W'(i);
      end
   end else begin : g_low
      always_comb begin
         idx = '0;
         for (int i = NUM_LINES - 1; i >= 0; i--)
            if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_LINES),
   localparam int BASE_W   = VEC_W - IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic                 cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   input  logic [NUM_LINES-1:0] irq_req,
   output logic                 irq_out,
   output logic [IDX_W-1:0]     irq_idx,
   output logic [VEC_W-1:0]     irq_vec
);
   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("irq_select: NUM_LINES must be a power of two and at least 2");
   end
   if (VEC_W <= IDX_W) begin : g_bad_vec
      $error("irq_select: VEC_W must exceed the index width");
   end
   if (DATA_W < NUM_LINES || DATA_W != VEC_W) begin : g_bad_data
      $error("irq_select: DATA_W must cover the mask and equal VEC_W");
   end

   logic [NUM_LINES-1:0] mask_q;
   logic [BASE_W-1:0]    base_q;
   logic [NUM_LINES-1:0] live;
   logic                 any;
   logic [IDX_W-1:0]     win;

   irq_cfg_regs #(
      .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .BASE_W(BASE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .mask_q(mask_q), .base_q(base_q)
   );

   irq_gate #(.NUM_LINES(NUM_LINES)) u_gate (
      .req(irq_req), .mask(mask_q), .live(live)
   );

   irq_prio_enc #(.NUM_LINES(NUM_LINES), .HIGH_WINS(1'b1)) u_enc (
      .vec(live), .any(any), .idx(win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out <= 1'b0;
         irq_idx <= '0;
         irq_vec <= '0;
      end else begin
         irq_out <= any;
         irq_idx <= any ? win : '0;
         irq_vec <= any ? {base_q, win} : '0;
      end
   end
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_LINES),
   localparam int BASE_W   = VEC_W - IDX_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic                 cfg_addr,
   input logic [DATA_W-1:0]    cfg_wdata,
   input logic [NUM_LINES-1:0] irq_req,
   input logic                 irq_out,
   input logic [IDX_W-1:0]     irq_idx,
   input logic [VEC_W-1:0]     irq_vec,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [BASE_W-1:0]    base_q
);
   localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (!irq_out && irq_idx == '0 && irq_vec == '0 && mask_q == '0)); // R1

   AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (|$past(irq_req & mask_q))); // R3

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_req & mask_q) == '0) |-> !irq_out); // R2

   AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (($past(irq_req & mask_q) >> irq_idx) == ONE)); // R4

   AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_vec[IDX_W-1:0] == irq_idx
                   && irq_vec[VEC_W-1:IDX_W] == $past(base_q))); // R5

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> (irq_idx == '0 && irq_vec == '0)); // R6

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we && !cfg_addr) |-> mask_q == $past(cfg_wdata[NUM_LINES-1:0])); // R7
endmodule

bind irq_select irq_select_chk #(
   .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_out(irq_out),
   .irq_idx(irq_idx), .irq_vec(irq_vec), .mask_q(mask_q), .base_q(base_q)
);

// File: tb/irq_select_test.sv
module irq_select_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_addr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] irq_req = '0;
   logic       irq_out;
   logic [2:0] irq_idx;
   logic [7:0] irq_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_select uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_out(irq_out),
      .irq_idx(irq_idx), .irq_vec(irq_vec)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int top_bit(input int v);
      int r = -1;
      for (int i = 0; i < 8; i++) if (((v >> i) & 1) != 0) r = i;
      return r;
   endfunction

   task automatic write_cfg(input logic a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_out(input int req, input int mask, input int base);
      int w = top_bit(req & mask);
      if (w < 0) begin
         check("R3 irq_out idle", int'(irq_out), 0);
         check("R6 idx idle", int'(irq_idx), 0);
         check("R6 vec idle", int'(irq_vec), 0);
         if (req != 0) check("R2 masked lines silent", int'(irq_out), 0);
      end else begin
         check("R3 irq_out set", int'(irq_out), 1);
         check("R4 winner index", int'(irq_idx), w);
         check("R5 vector", int'(irq_vec), ((base & 8'hF8) | w));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      irq_req = 8'hFF;
      @(posedge clk); @(negedge clk);
      check("R1 irq_out in reset", int'(irq_out), 0);
      check("R1 irq_idx in reset", int'(irq_idx), 0);
      check("R1 irq_vec in reset", int'(irq_vec), 0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1 mask cleared after reset", int'(irq_out), 0);
      check("R1 vec cleared after reset", int'(irq_vec), 0);

      // R8: output follows request one edge later, not before
      write_cfg(1'b0, 8'h10);
      irq_req = 8'h10;
      #1 check("R8 no change before edge", int'(irq_out), 0);
      @(posedge clk); @(negedge clk);
      check("R8 set after edge", int'(irq_out), 1);
      check("R8 idx after edge", int'(irq_idx), 4);

      // exhaustive sweep: every mask with every request pattern
      for (int m = 0; m < 256; m++) begin
         int b = (m * 37 + 11) & 255;
         irq_req = '0;
         write_cfg(1'b1, 8'(b));
         write_cfg(1'b0, 8'(m));
         for (int r = 0; r < 256; r++) begin
            irq_req = 8'(r);
            @(posedge clk); @(negedge clk);
            expect_out(r, m, b);
         end
      end

      // R7: mask write in the same cycle as a selection
      irq_req = 8'hFF;
      write_cfg(1'b0, 8'h06);
      write_cfg(1'b1, 8'hA8);
      @(posedge clk); @(negedge clk);
      check("R7 settled idx", int'(irq_idx), 2);
      cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h81;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      check("R7 old mask used at write edge", int'(irq_idx), 2);
      check("R7 old mask vector", int'(irq_vec), 8'hAA);
      @(posedge clk); @(negedge clk);
      check("R7 new mask next edge", int'(irq_idx), 7);

      // R7/R5: base write same cycle, low bits discarded
      cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h37;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      check("R7 old base at write edge", int'(irq_vec), 8'hAF);
      @(posedge clk); @(negedge clk);
      check("R5 new base, low bits dropped", int'(irq_vec), 8'h37);

      // R2: masked high line does not pre-empt enabled low line
      write_cfg(1'b0, 8'h01);
      irq_req = 8'h81;
      @(posedge clk); @(negedge clk);
      check("R2 masked line 7 ignored", int'(irq_idx), 0);
      check("R2 line 0 wins vector", int'(irq_vec), 8'h30);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule